// File: doc/BRIEF.md
# Split 64-bit Shift-and-Add Datapath

This block adds a shifted offset to a 64-bit pointer. The work is split between two 32-bit units that always issue together as a pair. The low unit shifts the second operand left by a small immediate and adds it to the low word of the first operand. The shift amount, the bits pushed out of the top of the low word, the extension state and the carry pass straight from the low unit to the high unit over an internal sideband, with no register in between. The high unit then builds its upper operand and adds it to the high word of the first operand.

A two-bit mode selects how the upper half of the offset is formed. In full mode it is the caller's high word. In zero-extend mode it is zero. In sign-extend mode it is copies of the offset's bit 31. The 64-bit result wraps modulo 2^64, and no overflow indication is produced. The pair's result is registered once and appears one cycle after a valid issue.

Top module: `sadd64_pair`

## Requirements
- R1: After reset is released, `valid_o` is 0 and both sum words are 0.
- R2: `valid_o` is 1 in the cycle after a cycle in which `pair_valid_i` was 1, and 0 otherwise.
- R3: In every mode, `sum_lo_o` equals the low 32 bits of `src1_lo_i + (offset << shamt_i)`.
- R4: In full mode (`mode_i` = 2'b00) the offset is `{src2_hi_i, src2_lo_i}`, and `{sum_hi_o, sum_lo_o}` equals `{src1_hi_i, src1_lo_i} + (offset << shamt_i)`.
- R5: In zero-extend mode (`mode_i` = 2'b01) the offset is `src2_lo_i` zero-extended to 64 bits, and `src2_hi_i` has no effect on either sum word.
- R6: In sign-extend mode (`mode_i` = 2'b10) the offset is `src2_lo_i` sign-extended from bit 31, and `src2_hi_i` has no effect.
- R7: `shamt_i` takes any value from 0 to 7. It shifts only the offset, and the bits shifted out of the low offset word land in the low bits of the high-half operand.
- R8: A carry out of the low 32-bit addition is added into the high word.
- R9: While `pair_valid_i` is 0, `sum_lo_o` and `sum_hi_o` keep their previous values.
- R10: Mode 2'b11 behaves exactly like full mode.
- R11: The 64-bit sum wraps modulo 2^64. The carry out of bit 63 is dropped and has no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pair_valid_i | input | 1 | Low and high operations issued together this cycle |
| mode_i | input | 2 | Offset mode: 00 full, 01 zero-extend, 10 sign-extend, 11 full |
| shamt_i | input | 3 | Left shift applied to the offset |
| src1_lo_i | input | 32 | Base pointer, low word |
| src1_hi_i | input | 32 | Base pointer, high word |
| src2_lo_i | input | 32 | Offset, low word |
| src2_hi_i | input | 32 | Offset, high word (full mode only) |
| valid_o | output | 1 | Result registered from the previous cycle's issue |
| sum_lo_o | output | 32 | Result, low word |
| sum_hi_o | output | 32 | Result, high word |

## Verification
The bench targets sign-extended negative offsets at shift 7. Here a design that drops the fill bits or the spilled bits returns a high word off by a large power of two. It drives carries that cross bit 31 in every mode, so a unit that loses the forwarded carry returns a high word one too small. It also sets `src2_hi_i` to garbage in the extend modes and brings the base pointer to 2^64-1, so a design that leaks the unused word, or that forms a 65-bit result, shows a wrong sum. It sweeps all eight shift amounts and runs idle cycles with scrambled inputs to catch outputs that fail to hold.

// File: rtl/sadd_pkg.sv
package sadd_pkg;
  localparam int HALF_W  = 32;
  localparam int SH_W    = 3;
  localparam int SPILL_W = (1 << SH_W) - 1;
  localparam int FULL_W  = 2 * HALF_W;

  typedef enum logic [1:0] {
    MODE_FULL = 2'b00,
    MODE_ZEXT = 2'b01,
    MODE_SEXT = 2'b10,
    MODE_ALT  = 2'b11
  } mode_e;

  // low-to-high forwarding, combinational within the pair
  typedef struct packed {
    logic [SH_W-1:0]    shamt;
    logic [SPILL_W-1:0] spill;
    logic               fill;
    logic               use_hi;
    logic               carry;
  } side_t;
endpackage

// File: rtl/sadd_lo_unit.sv
module sadd_lo_unit
  import sadd_pkg::*;
(
  input  logic [HALF_W-1:0] a_i,
  input  logic [HALF_W-1:0] b_i,
  input  mode_e             mode_i,
  input  logic [SH_W-1:0]   shamt_i,
  output logic [HALF_W-1:0] sum_o,
  output side_t             side_o
);
  localparam int WIDE_W = HALF_W + SPILL_W;

  logic [WIDE_W-1:0] wide;
  logic              carry;

  always_comb begin
    wide = {{SPILL_W{1'b0}}, b_i} << shamt_i;
    {carry, sum_o} = {1'b0, a_i} + {1'b0, wide[HALF_W-1:0]};
    side_o.shamt  = shamt_i;
    side_o.spill  = wide[WIDE_W-1:HALF_W];
    side_o.fill   = (mode_i == MODE_SEXT) && b_i[HALF_W-1];
    side_o.use_hi = (mode_i == MODE_FULL) || (mode_i == MODE_ALT);
    side_o.carry  = carry;
  end
endmodule

// File: rtl/sadd_hi_unit.sv
module sadd_hi_unit
  import sadd_pkg::*;
(
  input  logic [HALF_W-1:0] a_i,
  input  logic [HALF_W-1:0] b_i,
  input  side_t             side_i,
  output logic [HALF_W-1:0] sum_o
);
  logic [HALF_W-1:0] word;
  logic [HALF_W-1:0] upper;

  always_comb begin
    // upper word of the 64-bit offset before shifting
    word  = side_i.use_hi ? b_i : {HALF_W{side_i.fill}};
    upper = (word << side_i.shamt) | {{(HALF_W-SPILL_W){1'b0}}, side_i.spill};
    sum_o = a_i + upper + {{(HALF_W-1){1'b0}}, side_i.carry};
  end
endmodule

// File: rtl/sadd64_pair.sv
module sadd64_pair
  import sadd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pair_valid_i,
  input  logic [1:0]        mode_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic [HALF_W-1:0] src1_lo_i,
  input  logic [HALF_W-1:0] src1_hi_i,
  input  logic [HALF_W-1:0] src2_lo_i,
  input  logic [HALF_W-1:0] src2_hi_i,
  output logic              valid_o,
  output logic [HALF_W-1:0] sum_lo_o,
  output logic [HALF_W-1:0] sum_hi_o
);
  logic [HALF_W-1:0] lo_sum, hi_sum;
  side_t             side;

  sadd_lo_unit u_lo (
    .a_i     (src1_lo_i),
    .b_i     (src2_lo_i),
    .mode_i  (mode_e'(mode_i)),
    .shamt_i (shamt_i),
    .sum_o   (lo_sum),
    .side_o  (side)
  );

  sadd_hi_unit u_hi (
    .a_i    (src1_hi_i),
    .b_i    (src2_hi_i),
    .side_i (side),
    .sum_o  (hi_sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      sum_lo_o <= '0;
      sum_hi_o <= '0;
    end else begin
      valid_o <= pair_valid_i;
      if (pair_valid_i) begin
        sum_lo_o <= lo_sum;
        sum_hi_o <= hi_sum;
      end
    end
  end

  p_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_valid_i |=> valid_o);
  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pair_valid_i |=> !valid_o);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pair_valid_i |=> $stable(sum_lo_o) && $stable(sum_hi_o));
  p_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_valid_i && (mode_i == 2'b00) |=>
      {sum_hi_o, sum_lo_o} ==
      $past({src1_hi_i, src1_lo_i} + ({src2_hi_i, src2_lo_i} << shamt_i)));
  p_alt_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_valid_i && (mode_i == 2'b11) |=>
      {sum_hi_o, sum_lo_o} ==
      $past({src1_hi_i, src1_lo_i} + ({src2_hi_i, src2_lo_i} << shamt_i)));
  p_zext_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_valid_i && (mode_i == 2'b01) |=>
      {sum_hi_o, sum_lo_o} ==
      $past({src1_hi_i, src1_lo_i} + ({{HALF_W{1'b0}}, src2_lo_i} << shamt_i)));
  p_sext_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_valid_i && (mode_i == 2'b10) |=>
      {sum_hi_o, sum_lo_o} ==
      $past({src1_hi_i, src1_lo_i} +
            ({{HALF_W{src2_lo_i[HALF_W-1]}}, src2_lo_i} << shamt_i)));
  p_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_valid_i |=>
      sum_lo_o == $past(src1_lo_i + (src2_lo_i << shamt_i)));
endmodule

// File: tb/sim_sadd64_pair.sv
`timescale 1ns/1ps
module sim_sadd64_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pv = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [2:0]  sh = 3'd0;
  logic [31:0] a_lo = '0, a_hi = '0, b_lo = '0, b_hi = '0;
  logic        valid;
  logic [31:0] s_lo, s_hi;

  int unsigned total = 0, bad = 0;
  bit          done = 1'b0;

  typedef struct {
    logic [63:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  sadd64_pair u0 (
    .clk_i(clk), .rst_ni(rst_n), .pair_valid_i(pv), .mode_i(mode),
    .shamt_i(sh), .src1_lo_i(a_lo), .src1_hi_i(a_hi), .src2_lo_i(b_lo),
    .src2_hi_i(b_hi), .valid_o(valid), .sum_lo_o(s_lo), .sum_hi_o(s_hi)
  );

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_sum(input logic [1:0] m, input logic [2:0] s,
                                          input logic [63:0] a, input logic [63:0] b);
    logic [63:0] off;
    case (m)
      2'b01:   off = {32'h0, b[31:0]};
      2'b10:   off = {{32{b[31]}}, b[31:0]};
      default: off = b;
    endcase
    return a + (off << s);
  endfunction

  task automatic drive(input logic [1:0] m, input logic [2:0] s,
                       input logic [63:0] a, input logic [63:0] b, input string tag);
    item_t it;
    @(negedge clk);
    pv = 1'b1; mode = m; sh = s;
    {a_hi, a_lo} = a; {b_hi, b_lo} = b;
    it.exp = ref_sum(m, s, a, b);
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pv = 1'b0; mode = 2'(i); sh = 3'(i + 3);
      a_lo = $urandom; a_hi = $urandom; b_lo = $urandom; b_hi = $urandom;
    end
  endtask

  // monitor: pops on valid, checks hold (R9) and valid timing (R2) when idle
  logic [63:0] last = '0;
  bit          prev_pv = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (valid !== prev_pv) begin
        bad++;
        $display("FAIL R2 valid act=%b exp=%b", valid, prev_pv);
      end
      if (valid) begin
        if (q.size() == 0) begin
          total++; bad++;
          $display("FAIL R2 unexpected result act=%h exp=none", {s_hi, s_lo});
        end else begin
          item_t it;
          it = q.pop_front();
          check64(it.tag, {s_hi, s_lo}, it.exp);
        end
      end else begin
        check64("R9 hold", {s_hi, s_lo}, last);
      end
      last = {s_hi, s_lo};
    end
    prev_pv = pv;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    total++;
    if (valid !== 1'b0 || s_lo !== 32'h0 || s_hi !== 32'h0) begin
      bad++;
      $display("FAIL R1 act=%b/%h exp=0/0", valid, {s_hi, s_lo});
    end
    rst_n = 1'b1;
    idle(2);

    // R4 full mode basic and shifted
    drive(2'b00, 3'd0, 64'h0000_0001_0000_0010, 64'h0000_0002_0000_0020, "R4 full sh0");
    drive(2'b00, 3'd7, 64'h1234_5678_0000_0000, 64'h0300_0001_0200_0001, "R4 R7 full sh7 spill");
    // R8 carry across bit 31
    drive(2'b00, 3'd0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, "R8 full carry");
    drive(2'b01, 3'd1, 64'h0000_0005_8000_0000, 64'h0000_0000_4000_0000, "R8 zext carry");
    // R5 high offset word ignored
    drive(2'b01, 3'd4, 64'h0000_0000_0000_0001, 64'hDEAD_BEEF_F000_0001, "R5 zext hi ignored");
    drive(2'b01, 3'd7, 64'hAAAA_5555_1234_5678, 64'hFFFF_FFFF_FFFF_FFFF, "R5 zext sh7");
    // R6 signed negative, shift 7
    drive(2'b10, 3'd7, 64'h0000_0001_0000_0000, 64'h1357_9BDF_FFFF_FFFF, "R6 sext -1 sh7");
    drive(2'b10, 3'd7, 64'h0000_0000_0000_0080, 64'h0000_0000_FFFF_FFFF, "R6 sext to zero");
    drive(2'b10, 3'd3, 64'h0000_0010_0000_0000, 64'h0000_0000_8000_0000, "R6 sext min sh3");
    drive(2'b10, 3'd2, 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_7FFF_FFFF, "R6 sext positive");
    // R10 alternate code = full
    drive(2'b11, 3'd5, 64'h0000_0003_0000_0004, 64'h0000_0007_0800_0001, "R10 mode3 full");
    // R11 wrap
    drive(2'b00, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, "R11 wrap");
    drive(2'b10, 3'd1, 64'h0000_0000_0000_0001, 64'h0000_0000_FFFF_FFFF, "R11 sext wrap");
    idle(3);

    // R7 shift sweep in every mode, R3 low word covered by every compare
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 8; s++) begin
        drive(2'(m), 3'(s), 64'h7FFF_FFF0_F0F0_F0F0, 64'h8765_4321_C3C3_C3C3, "R7 R3 sweep");
      end
    end
    idle(2);

    // mixed traffic with gaps (R2, R9)
    for (int i = 0; i < 300; i++) begin
      drive(2'($urandom), 3'($urandom), {$urandom, $urandom}, {$urandom, $urandom}, "R3 R4 random");
      if ((i % 7) == 0) idle(1);
    end
    idle(3);

    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R2 pending act=%0d exp=0", q.size());
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule